// File: doc/BRIEF.md
# Fixed-Frequency PWM with Per-Cycle Current Limit

This block produces the chop-enable that gates a three-phase bridge. A free-running timebase sets a fixed PWM frequency. Each new period turns the drive on. When a synchronous overcurrent flag arrives, the drive is cut off for whatever is left of that period. The next period re-enables it. After each period start, a programmable blanking window makes the block deaf to the flag, so switching transients cannot end a period early.

A mode input also lets an external PWM waveform drive the bridge directly. In that case the internal limiter is either taken out of the path entirely, or kept as an absolute ceiling that can force the drive off inside an externally commanded on-time. A one-clock pulse marks every period that was cut short, so a fault counter downstream can count them. The period and blanking values are sampled only at the end of a period, so a new setting never produces a runt pulse.

Top module: `curlim_pwm`

## Requirements
- R1: The period counter runs from 0 up to the stored period value P and then wraps, so a PWM period lasts P+1 clocks. The cycle in which the count is 0 is the period start.
- R2: With mode 2'b00 (internal), chop_en_o is high from the period start. A trip accepted in the cycle with count c drives chop_en_o low from the next cycle to the end of the period.
- R3: The trip latch clears at every wrap, so each period begins with the latch clear. A trip that arrives in the last cycle of a period (count equal to P) is discarded.
- R4: With mode 2'b01 (external, unlimited), chop_en_o equals ext_pwm_i in the same cycle. trip_i is ignored: it sets no latch and raises no trip_pulse_o.
- R5: With mode 2'b10 or 2'b11 (external, clamped), chop_en_o is ext_pwm_i AND NOT the trip latch. Trips are accepted as in R2.
- R6: A trip is ignored while the count is below the stored blanking value B, that is at counts 0 to B-1 of each period.
- R7: trip_pulse_o is high for exactly one clock, in the cycle after the first accepted trip of a period. It never rises for later trips in the same period.
- R8: period_i and blank_i are sampled only in the last cycle of a period. The new values govern the next period, and changes at other times have no effect on the current one.
- R9: While reset is held, and until it has been released through the two-stage synchronizer, the count is 0, the latch is clear and trip_pulse_o is low. The stored period is 0, so the first active cycle is itself a wrap that loads period_i and blank_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_i | input | 12 | Period value P, sampled at period end |
| blank_i | input | 12 | Blanking length B, sampled at period end |
| trip_i | input | 1 | Synchronous overcurrent flag |
| ext_pwm_i | input | 1 | External PWM command |
| mode_i | input | 2 | 00 internal, 01 external unlimited, 10/11 external clamped |
| chop_en_o | output | 1 | Chop enable to the commutation stage |
| trip_pulse_o | output | 1 | One-clock pulse per early-terminated period |

## Verification
A trip can arrive in the same cycle as the period wrap. In that cycle the clear of the latch and a new trip collide, and the clear must win so that the next period still starts with the drive on. The bench provokes this by raising trip_i exactly when its own count reaches P. It also provokes it with random trips over short periods, and with period and blanking values changed in the same cycle. It then expects chop_en_o high and trip_pulse_o low in the following period-start cycle. A second collision, between the end of the blanking window and a trip, is judged at count B, where the trip must be accepted.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  parameter int unsigned CNT_W = 12;

  typedef enum logic [1:0] {
    MODE_INT        = 2'b00,
    MODE_EXT_FREE   = 2'b01,
    MODE_EXT_CLAMP  = 2'b10,
    MODE_EXT_CLAMP2 = 2'b11
  } cpwm_mode_e;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] blank_i,
  output logic         wrap_o,
  output logic         blanked_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, per_d;
  logic [W-1:0] blk_q, blk_d;
  logic         wrap;

  assign wrap = (cnt_q >= per_q);

  always_comb begin
    cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    per_d = per_q;
    blk_d = blk_q;
    if (wrap) begin
      cnt_d = '0;
      per_d = period_i;
      blk_d = blank_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      blk_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      blk_q <= blk_d;
    end
  end

  assign wrap_o    = wrap;
  assign blanked_o = (cnt_q < blk_q);

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
  p_wrap_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(per_q) && $stable(blk_q)));
endmodule

// File: rtl/cpwm_trip_latch.sv
module cpwm_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic limit_en_i,
  input  logic blanked_i,
  input  logic wrap_i,
  output logic latch_o,
  output logic pulse_o
);
  logic latch_q, latch_d;
  logic pulse_q, pulse_d;
  logic accept;

  assign accept = trip_i & limit_en_i & ~blanked_i & ~wrap_i;

  always_comb begin
    latch_d = latch_q | accept;
    pulse_d = accept & ~latch_q;
    if (wrap_i) latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      latch_q <= latch_d;
      pulse_q <= pulse_d;
    end
  end

  assign latch_o = latch_q;
  assign pulse_o = pulse_q;

  p_clear_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> !latch_q);
  p_blank_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blanked_i && !latch_q) |=> !latch_q);
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_pulse_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (latch_q && !$past(latch_q)));
endmodule

// File: rtl/cpwm_out_mux.sv
module cpwm_out_mux
  import cpwm_pkg::*;
(
  input  cpwm_mode_e mode_i,
  input  logic       ext_i,
  input  logic       latch_i,
  output logic       chop_o,
  output logic       limit_en_o
);
  always_comb begin
    limit_en_o = 1'b1;
    unique case (mode_i)
      MODE_INT:      chop_o = ~latch_i;
      MODE_EXT_FREE: begin
        chop_o     = ext_i;
        limit_en_o = 1'b0;
      end
      default:       chop_o = ext_i & ~latch_i;
    endcase
  end
endmodule

// File: rtl/curlim_pwm.sv
module curlim_pwm
  import cpwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] blank_i,
  input  logic         trip_i,
  input  logic         ext_pwm_i,
  input  logic [1:0]   mode_i,
  output logic         chop_en_o,
  output logic         trip_pulse_o
);
  logic       rst_m, rst_s;
  logic       wrap, blanked, latch, limit_en;
  cpwm_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign mode = cpwm_mode_e'(mode_i);

  cpwm_timebase #(.W(W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_s),
    .period_i (period_i),
    .blank_i  (blank_i),
    .wrap_o   (wrap),
    .blanked_o(blanked)
  );

  cpwm_trip_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_s),
    .trip_i    (trip_i),
    .limit_en_i(limit_en),
    .blanked_i (blanked),
    .wrap_i    (wrap),
    .latch_o   (latch),
    .pulse_o   (trip_pulse_o)
  );

  cpwm_out_mux u_mux (
    .mode_i    (mode),
    .ext_i     (ext_pwm_i),
    .latch_i   (latch),
    .chop_o    (chop_en_o),
    .limit_en_o(limit_en)
  );

  p_free_no_latch_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MODE_EXT_FREE && !latch) |=> (!latch && !trip_pulse_o));
  p_clamp_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_i[1] && latch) |-> !chop_en_o);
  p_internal_off_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MODE_INT && trip_pulse_o) |-> !chop_en_o);
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_s |-> (!trip_pulse_o && !latch));
endmodule

// File: tb/sim_curlim_pwm.sv
module sim_curlim_pwm;
  logic        clk, rst_n;
  logic [11:0] period_i, blank_i;
  logic        trip_i, ext_pwm_i;
  logic [1:0]  mode_i;
  logic        chop_en_o, trip_pulse_o;

  int n_chk, n_bad;
  string cur_tag;

  logic [11:0] mcnt, mper, mblk;
  logic        mlatch, mpulse;

  curlim_pwm u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic exp_chop(input logic [1:0] m, input logic e, input logic l);
    if (m == 2'b00) return ~l;
    if (m == 2'b01) return e;
    return e & ~l;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    if (m == 2'b00) return "R2";
    if (m == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary_and_end();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // One cycle: inputs already driven at negedge; check, advance model, cross posedge.
  task automatic step();
    logic wrap, acc, nlatch, npulse;
    logic [11:0] ncnt, nper, nblk;
    #1;
    check((cur_tag == "") ? mode_tag(mode_i) : cur_tag, "chop_en_o", chop_en_o,
          exp_chop(mode_i, ext_pwm_i, mlatch));
    check("R7", "trip_pulse_o", trip_pulse_o, mpulse);
    wrap   = (mcnt >= mper);
    acc    = trip_i & (mode_i != 2'b01) & ~(mcnt < mblk) & ~wrap;
    npulse = acc & ~mlatch;
    nlatch = wrap ? 1'b0 : (mlatch | acc);
    ncnt   = wrap ? 12'd0 : mcnt + 12'd1;
    nper   = wrap ? period_i : mper;
    nblk   = wrap ? blank_i : mblk;
    @(posedge clk);
    mcnt = ncnt; mper = nper; mblk = nblk; mlatch = nlatch; mpulse = npulse;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout");
    summary_and_end();
  end

  initial begin
    int last_pulse, spacing, cyc;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; period_i = 12'd9; blank_i = 12'd0; trip_i = 1'b0;
    ext_pwm_i = 1'b0; mode_i = 2'b00;
    mcnt = 0; mper = 0; mblk = 0; mlatch = 0; mpulse = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    #1;
    check("R9", "chop in reset", chop_en_o, 1'b1);
    check("R9", "pulse in reset", trip_pulse_o, 1'b0);
    rst_n = 1'b1;
    trip_i = 1'b1; // must be ignored while the synchronizer holds reset
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    #1;
    check("R9", "pulse during sync", trip_pulse_o, 1'b0);
    check("R9", "chop during sync", chop_en_o, 1'b1);
    trip_i = 1'b0;

    // R1: constant trip, pulse spacing equals P+1
    cur_tag = "R1"; period_i = 12'd9; blank_i = 12'd2; trip_i = 1'b1;
    last_pulse = -1; cyc = 0;
    for (int i = 0; i < 60; i++) begin
      step(); cyc++;
      if (trip_pulse_o) begin
        if (last_pulse >= 0 && i > 25) begin
          spacing = cyc - last_pulse;
          check("R1", "pulse spacing==P+1", spacing == 10, 1'b1);
        end
        last_pulse = cyc;
      end
    end

    // R6: trip only inside blanking window -> never latches
    cur_tag = "R6"; blank_i = 12'd4; period_i = 12'd9;
    for (int i = 0; i < 40; i++) begin
      trip_i = (mcnt < mblk) && (mper == 12'd9) && (mblk == 12'd4);
      step();
    end
    // R6: trip exactly at count B is accepted
    for (int i = 0; i < 20; i++) begin
      trip_i = (mcnt == mblk);
      step();
    end

    // R3: trip only in the last cycle of a period -> discarded
    cur_tag = "R3"; blank_i = 12'd0;
    for (int i = 0; i < 40; i++) begin
      trip_i = (mcnt == mper);
      step();
    end

    // R8: change period/blank mid-period
    cur_tag = "R8"; trip_i = 1'b1; blank_i = 12'd3;
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 3) begin
        period_i = 12'd4 + 12'($urandom % 12);
        blank_i  = 12'($urandom % 5);
      end
      step();
    end

    // Random phases across modes
    cur_tag = "";
    for (int ph = 0; ph < 24; ph++) begin
      mode_i   = 2'(ph % 4);
      period_i = 12'd1 + 12'($urandom % 20);
      blank_i  = 12'($urandom % 5);
      for (int i = 0; i < 300; i++) begin
        trip_i = ($urandom % 6) == 0;
        if (($urandom % 4) == 0) ext_pwm_i = ~ext_pwm_i;
        if (($urandom % 50) == 0) period_i = 12'($urandom % 16);
        step();
      end
    end

    // Directed: period of zero (every cycle a wrap) in clamped mode
    cur_tag = "R5"; mode_i = 2'b10; period_i = 12'd0; blank_i = 12'd0; trip_i = 1'b1;
    ext_pwm_i = 1'b1;
    for (int i = 0; i < 40; i++) step();

    summary_and_end();
  end
endmodule